// File: doc/BRIEF.md
# Processor error flag and halt controller

This block keeps a processor's error state and decides when the core has to stop. Four kinds of error event from the execution unit set a single sticky flag: overflow, divide by zero, bounds violation and a direct software set. The flag is cleared only by a test-and-clear command, which also returns the old value. A warm processor reset leaves the flag alone, so that a failed node can still be identified after its neighbours reset it. Only the cold power-on reset loads the flag, and the value it loads is a parameter.

A halt-on-error arm bit makes the block request a halt when the flag goes from clear to set. Arming the bit while the flag is already set does not halt the core. An analyse request also halts the core. For both kinds of halt the block captures an instruction pointer value into an accumulator register. After a halt request the links are given time to drain, and the halted status is raised only when they report idle. The external error pin is the OR of the flag and a synchronized external error input, so several processors can be chained into one error line. Around a high-priority preemption, both flags are saved to a single shadow entry and restored afterwards.

Top module: `err_halt_ctrl`

## Requirements
- R1: `err_o` is the OR of the internal flag and `err_ext_i`, where `err_ext_i` passes through a two-flop synchronizer. A rise on `err_ext_i` before clock edge k shows on `err_o` after edge k+1.
- R2: `err_ext_i` never changes the internal flag, never changes the halt state, and never changes `test_val_o`.
- R3: A one-cycle pulse on any one of `ovf_i`, `div0_i`, `bound_i` or `sw_set_i` sets the flag at the next edge.
- R4: Once set, the flag is cleared only by `test_clr_i`. Asserting `rst_ni` does not clear it. If a set event and `test_clr_i` arrive in the same cycle, the flag ends up set.
- R5: `test_val_o` shows the flag value as it stood before the clear, in the cycle in which `test_clr_i` is high.
- R6: `por_ni` loads the flag with parameter `ERR_INIT`. Both 0 and 1 are supported.
- R7: A halt is requested only when a set event arrives while the flag is 0 and the arm bit is already 1. Three cases do not halt: arming in the same cycle as the event, arming while the flag is 1, and a set event while the flag is already 1. The arm bit is set by `arm_halt_i` and cleared by `rst_ni`.
- R8: `preempt_enter_i` copies the flag and the arm bit into a shadow entry. The live values are kept, so the high-priority context starts with the same values. `preempt_exit_i` writes the shadow values back, undoing any change made in between.
- R9: On an error-triggered halt, `acc_o` becomes `iptr_i + 2`, where `iptr_i` is the pointer present in the cycle of the set event.
- R10: On an analyse-triggered halt, `acc_o` becomes `iptr_i + 1`. If an error trigger and `analyse_i` arrive in the same cycle, the error value (+2) is used.
- R11: `halt_req_o` rises at the edge after the trigger and holds until `rst_ni`. `halted_o` rises only at the edge after `link_idle_i` is seen high during a halt request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_ni | input | 1 | Cold power-on reset, active low; loads the flag |
| rst_ni | input | 1 | Warm processor reset, active low; flag is kept |
| ovf_i | input | 1 | Arithmetic overflow event |
| div0_i | input | 1 | Divide-by-zero event |
| bound_i | input | 1 | Bounds violation event |
| sw_set_i | input | 1 | Software set of the flag |
| err_ext_i | input | 1 | Asynchronous external error input |
| test_clr_i | input | 1 | Test-and-clear command |
| arm_halt_i | input | 1 | Set the halt-on-error arm bit |
| preempt_enter_i | input | 1 | Start of high-priority preemption |
| preempt_exit_i | input | 1 | End of high-priority preemption |
| analyse_i | input | 1 | Analyse (halt) request |
| link_idle_i | input | 1 | Links have no outstanding transfers |
| iptr_i | input | IP_W | Current instruction pointer |
| err_o | output | 1 | External error output |
| test_val_o | output | 1 | Current flag value (value before clear during test-and-clear) |
| halt_req_o | output | 1 | Halt request to core and links |
| halted_o | output | 1 | Core fully halted |
| acc_o | output | IP_W | Captured pointer copied to accumulator |

## Verification
The hardest state to reach is the save and restore of the arm bit across preemption. The arm bit has no port of its own, so its value can only be seen through a later halt decision. The bench arms halt inside a preemption, leaves the preemption, and then raises a clean 0-to-1 error. The absence of a halt request proves the restore. The arming corner cases are reached by pairing the arm command and an error in the same cycle, and by arming over a flag that is already set. Halt is sticky until warm reset, so the scenarios are separated by warm resets, and the same resets also show that the flag survives them.

// File: rtl/err_halt_pkg.sv
package err_halt_pkg;
  typedef enum logic [1:0] {
    HS_RUN    = 2'd0,
    HS_DRAIN  = 2'd1,
    HS_HALTED = 2'd2
  } halt_st_e;
endpackage

// File: rtl/err_sync.sv
module err_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/err_flag_ctx.sv
module err_flag_ctx #(
  parameter logic ERR_INIT = 1'b0
) (
  input  logic clk_i,
  input  logic por_ni,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic arm_i,
  input  logic enter_i,
  input  logic exit_i,
  output logic err_o,
  output logic hoe_o,
  output logic trig_o
);
  logic err_q, hoe_q, sh_err_q, sh_hoe_q;

  // flag survives warm reset; only power-on loads it
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) begin
      err_q    <= ERR_INIT;
      sh_err_q <= ERR_INIT;
    end else begin
      if (exit_i)     err_q <= sh_err_q;
      else if (set_i) err_q <= 1'b1;
      else if (clr_i) err_q <= 1'b0;
      if (enter_i && !exit_i) sh_err_q <= err_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hoe_q    <= 1'b0;
      sh_hoe_q <= 1'b0;
    end else begin
      if (exit_i)     hoe_q <= sh_hoe_q;
      else if (arm_i) hoe_q <= 1'b1;
      if (enter_i && !exit_i) sh_hoe_q <= hoe_q;
    end
  end

  assign err_o  = err_q;
  assign hoe_o  = hoe_q;
  // 0->1 edge of the flag with arm already set
  assign trig_o = set_i & ~err_q & hoe_q & ~exit_i;
endmodule

// File: rtl/err_halt_fsm.sv
module err_halt_fsm
  import err_halt_pkg::*;
#(
  parameter int IP_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            trig_i,
  input  logic            analyse_i,
  input  logic            link_idle_i,
  input  logic [IP_W-1:0] iptr_i,
  output logic            halt_req_o,
  output logic            halted_o,
  output logic [IP_W-1:0] acc_o
);
  localparam logic [IP_W-1:0] ERR_OFS = IP_W'(2);
  localparam logic [IP_W-1:0] ANA_OFS = IP_W'(1);

  halt_st_e        st_q;
  logic [IP_W-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= HS_RUN;
      acc_q <= '0;
    end else begin
      unique case (st_q)
        HS_RUN: begin
          if (trig_i) begin
            acc_q <= iptr_i + ERR_OFS;
            st_q  <= HS_DRAIN;
          end else if (analyse_i) begin
            acc_q <= iptr_i + ANA_OFS;
            st_q  <= HS_DRAIN;
          end
        end
        HS_DRAIN:  if (link_idle_i) st_q <= HS_HALTED;
        HS_HALTED: st_q <= HS_HALTED;
        default:   st_q <= HS_RUN;
      endcase
    end
  end

  assign halt_req_o = (st_q != HS_RUN);
  assign halted_o   = (st_q == HS_HALTED);
  assign acc_o      = acc_q;
endmodule

// File: rtl/err_halt_ctrl.sv
module err_halt_ctrl #(
  parameter int   IP_W        = 16,
  parameter int   SYNC_STAGES = 2,
  parameter logic ERR_INIT    = 1'b0
) (
  input  logic            clk_i,
  input  logic            por_ni,
  input  logic            rst_ni,
  input  logic            ovf_i,
  input  logic            div0_i,
  input  logic            bound_i,
  input  logic            sw_set_i,
  input  logic            err_ext_i,
  input  logic            test_clr_i,
  input  logic            arm_halt_i,
  input  logic            preempt_enter_i,
  input  logic            preempt_exit_i,
  input  logic            analyse_i,
  input  logic            link_idle_i,
  input  logic [IP_W-1:0] iptr_i,
  output logic            err_o,
  output logic            test_val_o,
  output logic            halt_req_o,
  output logic            halted_o,
  output logic [IP_W-1:0] acc_o
);
  logic ext_w, flag_w, hoe_w, trig_w, set_w;

  assign set_w = ovf_i | div0_i | bound_i | sw_set_i;

  err_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (err_ext_i),
    .q_o   (ext_w)
  );

  err_flag_ctx #(.ERR_INIT(ERR_INIT)) u_flag (
    .clk_i  (clk_i),
    .por_ni (por_ni),
    .rst_ni (rst_ni),
    .set_i  (set_w),
    .clr_i  (test_clr_i),
    .arm_i  (arm_halt_i),
    .enter_i(preempt_enter_i),
    .exit_i (preempt_exit_i),
    .err_o  (flag_w),
    .hoe_o  (hoe_w),
    .trig_o (trig_w)
  );

  err_halt_fsm #(.IP_W(IP_W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .trig_i     (trig_w),
    .analyse_i  (analyse_i),
    .link_idle_i(link_idle_i),
    .iptr_i     (iptr_i),
    .halt_req_o (halt_req_o),
    .halted_o   (halted_o),
    .acc_o      (acc_o)
  );

  assign err_o      = flag_w | ext_w;
  assign test_val_o = flag_w;
endmodule

// File: rtl/err_halt_chk.sv
module err_halt_chk #(
  parameter int IP_W = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            err_o,
  input logic            test_val_o,
  input logic            test_clr_i,
  input logic            preempt_exit_i,
  input logic            analyse_i,
  input logic            link_idle_i,
  input logic            halt_req_o,
  input logic            halted_o,
  input logic            hoe_q,
  input logic [IP_W-1:0] iptr_i,
  input logic [IP_W-1:0] acc_o
);
  // R1
  flag_reaches_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_val_o |-> err_o);

  // R4
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_val_o && !test_clr_i && !preempt_exit_i |=> test_val_o);

  // R7
  halt_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halt_req_o) && !$past(analyse_i) |-> $past(hoe_q) && !$past(test_val_o));

  // R9
  err_ptr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halt_req_o) && !$past(analyse_i) |-> acc_o == $past(iptr_i) + IP_W'(2));

  // R11
  halt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_req_o |=> halt_req_o);

  // R11
  halted_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> halt_req_o);

  // R11
  halted_after_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halted_o) |-> $past(link_idle_i));
endmodule

bind err_halt_ctrl err_halt_chk #(.IP_W(IP_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .err_o         (err_o),
  .test_val_o    (test_val_o),
  .test_clr_i    (test_clr_i),
  .preempt_exit_i(preempt_exit_i),
  .analyse_i     (analyse_i),
  .link_idle_i   (link_idle_i),
  .halt_req_o    (halt_req_o),
  .halted_o      (halted_o),
  .hoe_q         (hoe_w),
  .iptr_i        (iptr_i),
  .acc_o         (acc_o)
);

// File: tb/err_halt_ctrl_tb.sv
module err_halt_ctrl_tb;
  localparam int IP_W = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic por_n, rst_n;
  logic ovf, div0, bound, sws, ext, tclr, arm, penter, pexit, ana, lidle;
  logic [IP_W-1:0] iptr;
  logic err_a, tv_a, hr_a, hd_a;
  logic err_b, tv_b, hr_b, hd_b;
  logic [IP_W-1:0] acc_a, acc_b;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  err_halt_ctrl #(.IP_W(IP_W), .ERR_INIT(1'b0)) u_dut (
    .clk_i(clk), .por_ni(por_n), .rst_ni(rst_n),
    .ovf_i(ovf), .div0_i(div0), .bound_i(bound), .sw_set_i(sws),
    .err_ext_i(ext), .test_clr_i(tclr), .arm_halt_i(arm),
    .preempt_enter_i(penter), .preempt_exit_i(pexit),
    .analyse_i(ana), .link_idle_i(lidle), .iptr_i(iptr),
    .err_o(err_a), .test_val_o(tv_a), .halt_req_o(hr_a),
    .halted_o(hd_a), .acc_o(acc_a));

  err_halt_ctrl #(.IP_W(IP_W), .ERR_INIT(1'b1)) u_dut_p1 (
    .clk_i(clk), .por_ni(por_n), .rst_ni(rst_n),
    .ovf_i(1'b0), .div0_i(1'b0), .bound_i(1'b0), .sw_set_i(1'b0),
    .err_ext_i(1'b0), .test_clr_i(tclr), .arm_halt_i(1'b0),
    .preempt_enter_i(1'b0), .preempt_exit_i(1'b0),
    .analyse_i(1'b0), .link_idle_i(1'b0), .iptr_i(iptr),
    .err_o(err_b), .test_val_o(tv_b), .halt_req_o(hr_b),
    .halted_o(hd_b), .acc_o(acc_b));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic pulse_src(input int src);
    @(negedge clk);
    ovf = (src == 0); div0 = (src == 1); bound = (src == 2); sws = (src == 3);
    @(negedge clk);
    ovf = 0; div0 = 0; bound = 0; sws = 0;
    #1;
  endtask

  task automatic clear_flag(input string req, input logic prev);
    @(negedge clk);
    tclr = 1;
    #1 chk(req, tv_a, prev);
    @(negedge clk);
    tclr = 0;
    #1 chk(req, tv_a, 1'b0);
  endtask

  task automatic warm_reset();
    @(negedge clk);
    rst_n = 0;
    step();
    rst_n = 1;
    step();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    por_n = 0; rst_n = 0;
    {ovf, div0, bound, sws, ext, tclr, arm, penter, pexit, ana, lidle} = '0;
    iptr = '0;
    #23;
    por_n = 1;
    #10;
    // R6: power-up value for both parameter settings
    chk("R6 init0", tv_a, 1'b0);
    chk("R6 init1", tv_b, 1'b1);
    chk("R11 reset halt", {30'd0, hr_a, hd_a}, 0);
    rst_n = 1;
    step();
    // R6 init1 survives warm reset; R5 returns old value on clear
    @(negedge clk); tclr = 1;
    #1 chk("R5 init1 old value", tv_b, 1'b1);
    @(negedge clk); tclr = 0;
    #1 chk("R4 init1 cleared", tv_b, 1'b0);

    // R3 every source sets the flag; R5 clear returns old value
    for (int s = 0; s < 4; s++) begin
      pulse_src(s);
      chk($sformatf("R3 src%0d", s), tv_a, 1'b1);
      clear_flag("R5 clear", 1'b1);
    end

    // R1 sweep external input x flag, with two-edge synchronizer latency
    for (int f = 0; f < 2; f++) begin
      if (f == 1) pulse_src(3);
      @(negedge clk); ext = 1;
      #1 chk("R1 ext before sync", err_a, f);
      step();
      chk("R1 ext one edge", err_a, f);
      step();
      chk("R1 ext two edges", err_a, 1'b1);
      // R2: external input leaves the flag alone
      chk("R2 flag untouched", tv_a, f);
      @(negedge clk); ext = 0;
      step(); step();
      chk("R1 ext released", err_a, f);
      if (f == 1) clear_flag("R5 clear", 1'b1);
    end

    // R4 set wins over clear in the same cycle
    @(negedge clk); tclr = 1; ovf = 1;
    @(negedge clk); tclr = 0; ovf = 0;
    #1 chk("R4 set beats clear", tv_a, 1'b1);
    // R4 warm reset keeps flag
    warm_reset();
    chk("R4 flag across reset", tv_a, 1'b1);
    chk("R4 flag on pin", err_a, 1'b1);

    // R7 arming with flag already 1, then another event: no halt
    @(negedge clk); arm = 1;
    @(negedge clk); arm = 0;
    pulse_src(0);
    step();
    chk("R7 arm over set flag", hr_a, 1'b0);

    // R2 external input with arm set and flag 0: no halt, flag stays 0
    clear_flag("R5 clear", 1'b1);
    @(negedge clk); ext = 1;
    step(); step(); step();
    chk("R2 no halt from ext", hr_a, 1'b0);
    chk("R2 flag stays 0", tv_a, 1'b0);
    chk("R1 pin follows ext", err_a, 1'b1);
    @(negedge clk); ext = 0;
    step(); step();

    // R7 arm in same cycle as first event: no halt (new reset clears arm)
    warm_reset();
    @(negedge clk); arm = 1; div0 = 1;
    @(negedge clk); arm = 0; div0 = 0;
    #1 chk("R7 same cycle arm", hr_a, 1'b0);
    step();
    chk("R7 same cycle arm later", hr_a, 1'b0);

    // R7/R9/R11 real error halt
    clear_flag("R5 clear", 1'b1);
    @(negedge clk); iptr = 16'h1230; bound = 1;
    @(negedge clk); bound = 0; iptr = 16'h7777;
    #1 chk("R7 halt request", hr_a, 1'b1);
    chk("R9 acc +2", acc_a, 16'h1232);
    chk("R11 not halted before idle", hd_a, 1'b0);
    step(); step();
    chk("R11 waits for idle", hd_a, 1'b0);
    @(negedge clk); lidle = 1;
    #1 chk("R11 idle just seen", hd_a, 1'b0);
    step();
    chk("R11 halted", hd_a, 1'b1);
    chk("R11 request held", hr_a, 1'b1);
    lidle = 0;
    warm_reset();
    chk("R11 reset clears halt", {30'd0, hr_a, hd_a}, 0);
    chk("R4 flag after halt reset", tv_a, 1'b1);

    // R10 analyse halt
    @(negedge clk); iptr = 16'h0456; ana = 1;
    @(negedge clk); ana = 0;
    #1 chk("R10 analyse halt", hr_a, 1'b1);
    chk("R10 acc +1", acc_a, 16'h0457);
    warm_reset();

    // R10 error and analyse together: error wins
    clear_flag("R5 clear", 1'b1);
    @(negedge clk); arm = 1;
    @(negedge clk); arm = 0; iptr = 16'hfffe; sws = 1; ana = 1;
    @(negedge clk); sws = 0; ana = 0;
    #1 chk("R10 error priority", acc_a, 16'h0000);
    chk("R10 halt req", hr_a, 1'b1);
    warm_reset();

    // R8 flag saved and restored; high priority sees a copy
    @(negedge clk); penter = 1;
    @(negedge clk); penter = 0;
    #1 chk("R8 copy into high", tv_a, 1'b1);
    clear_flag("R5 clear high", 1'b1);
    @(negedge clk); pexit = 1;
    @(negedge clk); pexit = 0;
    #1 chk("R8 flag restored", tv_a, 1'b1);

    // R8 arm bit restored: armed at high priority, gone after exit
    clear_flag("R5 clear", 1'b1);
    @(negedge clk); penter = 1;
    @(negedge clk); penter = 0; arm = 1;
    @(negedge clk); arm = 0; pexit = 1;
    @(negedge clk); pexit = 0;
    pulse_src(2);
    chk("R8 arm restored no halt", hr_a, 1'b0);
    chk("R8 flag set low prio", tv_a, 1'b1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule